// File: doc/BRIEF.md
# SPI Master with Per-Word Chip-Select Tags

This block is a serial peripheral interface master fed from a 32-bit transmit queue. Every queued word carries its own controls in the upper half: a chip-select bit pattern and an index that picks one of several clock and frame-width settings. The payload sits in the lower half. As a result, one stream of words can address different devices, or change speed, from one frame to the next without any reprogramming between frames.

Each frame shifts data out and in at the same time. Whatever comes back is queued in a receive FIFO, whether or not anyone intends to read it. When that FIFO is full, the new byte is dropped, a sticky overrun flag is raised, and transmission carries on. A fill-request line stays high while the transmit queue has space, so a DMA engine or an interrupt handler can keep the queue topped up.

Top module: `spi_tagged_master`

## Requirements
- R1: A pushed word is laid out as data in bits [15:0] (8-bit frames use bits [7:0]), chip-select pattern in bits [23:16], and attribute index in bits [31:24]. For each set bit k of the pattern, `cs_n[k]` is driven low for that frame. Pattern 1 gives `cs_n`=8'hFE, pattern 2 gives 8'hFD, and pattern 3 gives 8'hFC.
- R2: The bus runs in mode 0. `sclk` idles low. `mosi` presents the data MSB first and is stable at each rising `sclk` edge. `miso` is sampled on the rising edge, and every bit of the frame is shifted out.
- R3: The attribute index selects set i, which gives a half-period of `cfg_half_div[4i+3:4i]` clocks (0 is treated as 1) and a frame width of 16 bits when `cfg_wide[i]`=1, otherwise 8 bits. An index of 4 or more selects set 0. For an isolated frame, the chip select stays low for 2 × half-period × width clocks. With a half-period of 1 and 8 bits, that is 16 clocks.
- R4: When the next queued word has the same pattern as the frame that is ending, the next frame starts at once and the chip select stays low without a break.
- R5: When the pattern changes, or the queue runs empty, every `cs_n` line goes high for at least one serial-clock period (2 × half-period clocks) before the next frame. `cs_n` never moves directly from one active pattern to another.
- R6: Each completed frame pushes its received bits into the RX FIFO in order. 8-bit frames are zero-extended to 16 bits. Popping with `rx_rd_en` moves to the next entry.
- R7: When a frame completes with the 4-entry RX FIFO full, the new data is dropped and `rx_overrun` is set. The flag stays set through later reads, and transmission continues without stalling.
- R8: A one-cycle pulse on `rx_clear` empties the RX FIFO and clears `rx_overrun`. After the clear, the FIFO accepts new data normally.
- R9: The fill request is high while `req_en`=1 and the 4-entry TX queue is not full. It drives `dma_req` when `req_to_dma`=1 and `irq_req` otherwise. The unselected output stays low.
- R10: After reset, `sclk`=0, `mosi`=0, `cs_n` is all ones, `rx_empty`=1, `rx_overrun`=0 and `tx_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_en | input | 1 | Push `tx_wr_data` into the TX queue |
| tx_wr_data | input | 32 | Tagged push word |
| tx_full | output | 1 | TX queue holds 4 words |
| rx_rd_en | input | 1 | Pop the RX FIFO head |
| rx_rd_data | output | 16 | RX FIFO head |
| rx_empty | output | 1 | RX FIFO holds nothing |
| rx_clear | input | 1 | Empty the RX FIFO and clear overrun |
| rx_overrun | output | 1 | Sticky lost-data flag |
| req_en | input | 1 | Enable the fill request |
| req_to_dma | input | 1 | 1 routes the request to `dma_req`, 0 to `irq_req` |
| dma_req | output | 1 | Fill request toward DMA |
| irq_req | output | 1 | Fill request toward the interrupt path |
| cfg_half_div | input | 16 | Four 4-bit half-period settings, set i at [4i+3:4i] |
| cfg_wide | input | 4 | Per-set 16-bit frame select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
The bench runs back-to-back frames that share a pattern. A design that releases the select between such frames shows two short low periods in place of one 32-clock period. It also runs frames whose patterns differ. A design that swaps selects directly, or whose gap is shorter than a serial-clock period, trips the gap monitor. Frames at a slow divider and at 16 bits show up divider or width errors as a wrong low-time or as a clipped bit stream on the bus. The overrun scenario keeps feeding six frames into a four-entry receive queue. A design that stalls sends fewer than 48 bits, one that overwrites old data returns the wrong first bytes, and one that clears the flag on a read loses the sticky overrun.

// File: rtl/spi_tagged_pkg.sv
package spi_tagged_pkg;

  // Field positions inside a push word; the engine decodes these.
  localparam int DATA_W      = 16;
  localparam int CS_LSB      = 16;
  localparam int CS_FIELD_W  = 8;
  localparam int ATTR_LSB    = 24;
  localparam int ATTR_IDX_W  = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d;
  logic [AW-1:0]    rptr_q, rptr_d;
  logic [AW:0]      cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_wr   = wr_en && !full && !clr;
  assign do_rd   = rd_en && !empty && !clr;
  assign rd_data = mem_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_wr) wptr_d = wptr_q + 1'b1;
      if (do_rd) rptr_d = rptr_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wptr_q] <= wr_data;
  end

endmodule

// File: rtl/spi_attr_sel.sv
module spi_attr_sel #(
  parameter int NUM_ATTR = 4,
  parameter int DIV_W    = 4,
  parameter int IDX_W    = 8
) (
  input  logic [IDX_W-1:0]          attr_idx,
  input  logic [NUM_ATTR*DIV_W-1:0] cfg_half_div,
  input  logic [NUM_ATTR-1:0]       cfg_wide,
  output logic [DIV_W-1:0]          half_div,
  output logic                      wide
);

  localparam int ATTR_W = $clog2(NUM_ATTR);
  localparam logic [IDX_W-1:0] IDX_LIMIT = NUM_ATTR[IDX_W-1:0];

  logic [ATTR_W-1:0] sel;

  // Out-of-range indices fall back to set 0.
  assign sel = (attr_idx < IDX_LIMIT) ? attr_idx[ATTR_W-1:0] : '0;

  always_comb begin
    half_div = cfg_half_div[DIV_W-1:0];
    wide     = cfg_wide[0];
    for (int i = 1; i < NUM_ATTR; i++) begin
      if (sel == i[ATTR_W-1:0]) begin
        half_div = cfg_half_div[i*DIV_W +: DIV_W];
        wide     = cfg_wide[i];
      end
    end
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_out,
  input  logic              shift_in,
  input  logic              wide,
  input  logic              active,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load) begin
      tx_d = load_data;
      rx_d = '0;
    end else begin
      if (shift_out) tx_d = {tx_q[DATA_W-2:0], 1'b0};
      if (shift_in)  rx_d = {rx_q[DATA_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi    = active && (wide ? tx_q[DATA_W-1] : tx_q[HALF_W-1]);
  assign rx_word = wide ? rx_q : {{HALF_W{1'b0}}, rx_q[HALF_W-1:0]};

endmodule

// File: rtl/spi_sequencer.sv
module spi_sequencer
  import spi_tagged_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [NUM_CS-1:0] head_cs,
  input  logic [DIV_W-1:0]  head_div,
  input  logic              head_wide,
  output logic              start,
  output logic              bit_rise,
  output logic              bit_fall,
  output logic              frame_done,
  output logic              shifting,
  output logic              cur_wide,
  output logic              sclk,
  output logic [NUM_CS-1:0] cs_n
);

  localparam int CNT_W = DIV_W + 1;

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  div_q, div_d;
  logic [4:0]        bits_q, bits_d;
  logic [NUM_CS-1:0] pat_q, pat_d;
  logic              wide_q, wide_d;
  logic              sclk_q, sclk_d;
  logic [NUM_CS-1:0] csn_q, csn_d;
  logic [CNT_W-1:0]  head_half;
  logic              last_bit;

  assign head_half = (head_div == '0) ? CNT_W'(1) : {1'b0, head_div};
  assign last_bit  = (bits_q == (wide_q ? 5'd16 : 5'd8));

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    div_d      = div_q;
    bits_d     = bits_q;
    pat_d      = pat_q;
    wide_d     = wide_q;
    sclk_d     = sclk_q;
    csn_d      = csn_q;
    start      = 1'b0;
    bit_rise   = 1'b0;
    bit_fall   = 1'b0;
    frame_done = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        sclk_d = 1'b0;
        if (tx_valid) start = 1'b1;
      end
      SEQ_SHIFT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          cnt_d = div_q - 1'b1;
          if (!sclk_q) begin
            bit_rise = 1'b1;
            sclk_d   = 1'b1;
            bits_d   = bits_q + 1'b1;
          end else begin
            bit_fall = 1'b1;
            sclk_d   = 1'b0;
            if (last_bit) begin
              frame_done = 1'b1;
              if (tx_valid && (head_cs == pat_q)) begin
                start = 1'b1;
              end else begin
                state_d = SEQ_GAP;
                csn_d   = '1;
                cnt_d   = {div_q[CNT_W-2:0], 1'b0} - 1'b1;
              end
            end
          end
        end
      end
      SEQ_GAP: begin
        if (cnt_q == '0) state_d = SEQ_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
    if (start) begin
      state_d = SEQ_SHIFT;
      div_d   = head_half;
      cnt_d   = head_half - 1'b1;
      bits_d  = '0;
      pat_d   = head_cs;
      wide_d  = head_wide;
      csn_d   = ~head_cs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      div_q   <= CNT_W'(1);
      bits_q  <= '0;
      pat_q   <= '0;
      wide_q  <= 1'b0;
      sclk_q  <= 1'b0;
      csn_q   <= '1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      div_q   <= div_d;
      bits_q  <= bits_d;
      pat_q   <= pat_d;
      wide_q  <= wide_d;
      sclk_q  <= sclk_d;
      csn_q   <= csn_d;
    end
  end

  assign shifting = (state_q == SEQ_SHIFT);
  assign cur_wide = wide_q;
  assign sclk     = sclk_q;
  assign cs_n     = csn_q;

endmodule

// File: rtl/spi_tagged_master.sv
module spi_tagged_master
  import spi_tagged_pkg::*;
#(
  parameter int NUM_CS   = 8,
  parameter int NUM_ATTR = 4,
  parameter int DIV_W    = 4,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tx_wr_en,
  input  logic [31:0]               tx_wr_data,
  output logic                      tx_full,
  input  logic                      rx_rd_en,
  output logic [DATA_W-1:0]         rx_rd_data,
  output logic                      rx_empty,
  input  logic                      rx_clear,
  output logic                      rx_overrun,
  input  logic                      req_en,
  input  logic                      req_to_dma,
  output logic                      dma_req,
  output logic                      irq_req,
  input  logic [NUM_ATTR*DIV_W-1:0] cfg_half_div,
  input  logic [NUM_ATTR-1:0]       cfg_wide,
  output logic                      sclk,
  output logic                      mosi,
  input  logic                      miso,
  output logic [NUM_CS-1:0]         cs_n
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Transmit queue
  logic [31:0]           tx_head;
  logic                  tx_empty;
  logic                  tx_pop;
  logic [NUM_CS-1:0]     head_cs;
  logic [ATTR_IDX_W-1:0] head_attr;
  logic [DIV_W-1:0]      head_div;
  logic                  head_wide;

  spi_sync_fifo #(.WIDTH(32), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (1'b0),
    .wr_en   (tx_wr_en),
    .wr_data (tx_wr_data),
    .rd_en   (tx_pop),
    .rd_data (tx_head),
    .empty   (tx_empty),
    .full    (tx_full)
  );

  assign head_cs   = tx_head[CS_LSB +: NUM_CS];
  assign head_attr = tx_head[ATTR_LSB +: ATTR_IDX_W];

  spi_attr_sel #(.NUM_ATTR(NUM_ATTR), .DIV_W(DIV_W), .IDX_W(ATTR_IDX_W)) u_attr (
    .attr_idx     (head_attr),
    .cfg_half_div (cfg_half_div),
    .cfg_wide     (cfg_wide),
    .half_div     (head_div),
    .wide         (head_wide)
  );

  // Frame sequencing and shifting
  logic bit_rise, bit_fall, frame_done, shifting, cur_wide;
  logic [DATA_W-1:0] rx_word;

  spi_sequencer #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tx_valid   (!tx_empty),
    .head_cs    (head_cs),
    .head_div   (head_div),
    .head_wide  (head_wide),
    .start      (tx_pop),
    .bit_rise   (bit_rise),
    .bit_fall   (bit_fall),
    .frame_done (frame_done),
    .shifting   (shifting),
    .cur_wide   (cur_wide),
    .sclk       (sclk),
    .cs_n       (cs_n)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (tx_pop),
    .load_data (tx_head[DATA_W-1:0]),
    .shift_out (bit_fall && !frame_done),
    .shift_in  (bit_rise),
    .wide      (cur_wide),
    .active    (shifting),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  // Receive queue and overrun flag
  logic rx_full;
  logic ovr_q, ovr_d;

  spi_sync_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (rx_clear),
    .wr_en   (frame_done),
    .wr_data (rx_word),
    .rd_en   (rx_rd_en),
    .rd_data (rx_rd_data),
    .empty   (rx_empty),
    .full    (rx_full)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (rx_clear)                    ovr_d = 1'b0;
    else if (frame_done && rx_full)  ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ovr_q <= 1'b0;
    else            ovr_q <= ovr_d;
  end
  assign rx_overrun = ovr_q;

  // Fill request routing
  logic fill_req;
  assign fill_req = req_en && !tx_full;
  assign dma_req  = fill_req && req_to_dma;
  assign irq_req  = fill_req && !req_to_dma;

endmodule

// File: rtl/spi_tagged_master_chk.sv
module spi_tagged_master_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_full,
  input logic              dma_req,
  input logic              irq_req,
  input logic              rx_clear,
  input logic              rx_empty,
  input logic              rx_overrun,
  input logic [NUM_CS-1:0] cs_n
);

  assert_req_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req || irq_req) |-> !tx_full);

  assert_req_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dma_req, irq_req}) <= 1);

  assert_cs_no_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |=> ((cs_n == '1) || $stable(cs_n)));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !rx_clear) |=> rx_overrun);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clear |=> (rx_empty && !rx_overrun));

endmodule

bind spi_tagged_master spi_tagged_master_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_full    (tx_full),
  .dma_req    (dma_req),
  .irq_req    (irq_req),
  .rx_clear   (rx_clear),
  .rx_empty   (rx_empty),
  .rx_overrun (rx_overrun),
  .cs_n       (cs_n)
);

// File: tb/test_spi_tagged_master.sv
`timescale 1ns/1ps
module test_spi_tagged_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_wr_en;
  logic [31:0] tx_wr_data;
  logic        tx_full;
  logic        rx_rd_en;
  logic [15:0] rx_rd_data;
  logic        rx_empty;
  logic        rx_clear;
  logic        rx_overrun;
  logic        req_en;
  logic        req_to_dma;
  logic        dma_req;
  logic        irq_req;
  logic [15:0] cfg_half_div;
  logic [3:0]  cfg_wide;
  logic        sclk;
  logic        mosi;
  logic        miso;
  logic [7:0]  cs_n;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_tagged_master i_spi_tagged_master (
    .clk(clk), .rst_n(rst_n), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .tx_full(tx_full), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
    .rx_empty(rx_empty), .rx_clear(rx_clear), .rx_overrun(rx_overrun),
    .req_en(req_en), .req_to_dma(req_to_dma), .dma_req(dma_req),
    .irq_req(irq_req), .cfg_half_div(cfg_half_div), .cfg_wide(cfg_wide),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // Slave model: a continuous MISO bit stream, one bit per falling sclk.
  logic [0:127] stream = 128'h5AC3961EE73C817E24DB69F00DB24BA5;
  logic         mon_clr = 1'b0;
  logic [7:0]   miso_ptr;
  assign miso = stream[miso_ptr[6:0]];

  always @(negedge sclk or posedge mon_clr) begin
    if (mon_clr) miso_ptr <= '0;
    else         miso_ptr <= miso_ptr + 1'b1;
  end

  // Bus capture on rising sclk
  logic [0:255] mosi_log;
  logic [7:0]   cs_log [0:255];
  int           bit_idx;

  always @(posedge sclk or posedge mon_clr) begin
    if (mon_clr) bit_idx <= 0;
    else begin
      mosi_log[bit_idx[7:0]] <= mosi;
      cs_log[bit_idx[7:0]]   <= cs_n;
      bit_idx <= bit_idx + 1;
    end
  end

  // Chip-select low-time and gap monitor
  int         run_log [0:15];
  int         gap_log [0:15];
  int         run_n, gap_n, run_cnt, gap_cnt;
  bit         had_run, direct_chg;
  logic [7:0] prev_cs;

  always @(negedge clk) begin
    if (mon_clr) begin
      run_n = 0; gap_n = 0; run_cnt = 0; gap_cnt = 0;
      had_run = 0; direct_chg = 0; prev_cs = 8'hFF;
    end else begin
      if (cs_n != 8'hFF) begin
        if (prev_cs == 8'hFF) begin
          if (had_run && gap_n < 16) begin gap_log[gap_n] = gap_cnt; gap_n++; end
        end else if (cs_n != prev_cs) direct_chg = 1;
        run_cnt++;
      end else begin
        if (prev_cs != 8'hFF) begin
          if (run_n < 16) begin run_log[run_n] = run_cnt; run_n++; end
          run_cnt = 0; had_run = 1; gap_cnt = 0;
        end
        gap_cnt++;
      end
      prev_cs = cs_n;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] pat, input logic [7:0] attr,
                                     input logic [15:0] data);
    return {attr, pat, data};
  endfunction

  task automatic clear_mon();
    @(posedge clk); #1 mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    while (tx_full) @(negedge clk);
    tx_wr_en = 1'b1; tx_wr_data = w;
    @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 20) begin
      @(negedge clk);
      if (cs_n == 8'hFF && !sclk) quiet++; else quiet = 0;
    end
  endtask

  task automatic pop_expect(input string req, input logic [15:0] exp);
    @(negedge clk);
    check({req, " rx not empty"}, rx_empty, 0);
    check({req, " rx data"}, rx_rd_data, exp);
    rx_rd_en = 1'b1;
    @(negedge clk);
    rx_rd_en = 1'b0;
  endtask

  function automatic logic [15:0] sent_bits(input int first, input int n);
    logic [15:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[14:0], mosi_log[first + i]};
    return v;
  endfunction

  function automatic logic [7:0] sbyte(input int k);
    return stream[8*k +: 8];
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check("R10 sclk", sclk, 0);
    check("R10 mosi", mosi, 0);
    check("R10 cs_n", cs_n, 8'hFF);
    check("R10 rx_empty", rx_empty, 1);
    check("R10 rx_overrun", rx_overrun, 0);
    check("R10 tx_full", tx_full, 0);
  endtask

  task automatic t_request();
    req_en = 1'b0; req_to_dma = 1'b0;
    @(negedge clk);
    check("R9 disabled dma", dma_req, 0);
    check("R9 disabled irq", irq_req, 0);
    req_en = 1'b1;
    @(negedge clk);
    check("R9 irq route irq", irq_req, 1);
    check("R9 irq route dma", dma_req, 0);
    req_to_dma = 1'b1;
    @(negedge clk);
    check("R9 dma route dma", dma_req, 1);
    check("R9 dma route irq", irq_req, 0);
  endtask

  task automatic t_single();
    clear_mon();
    push(mk(8'h01, 8'h00, 16'h00A5));
    wait_idle();
    check("R2 bit count", bit_idx, 8);
    check("R2 msb-first data", sent_bits(0, 8), 16'h00A5);
    check("R1 pattern 1 select", cs_log[0], 8'hFE);
    check("R3 8-bit low time", run_log[0], 16);
    pop_expect("R6 single", {8'h00, sbyte(0)});
    @(negedge clk);
    check("R6 drained", rx_empty, 1);
  endtask

  task automatic t_chain();
    clear_mon();
    push(mk(8'h03, 8'h00, 16'h003C));
    push(mk(8'h03, 8'h00, 16'h00C3));
    wait_idle();
    check("R4 one continuous low period", run_n, 1);
    check("R4 chained low time", run_log[0], 32);
    check("R1 pattern 3 first", cs_log[0], 8'hFC);
    check("R1 pattern 3 second", cs_log[8], 8'hFC);
    check("R2 chained data", sent_bits(0, 16), 16'h3CC3);
    pop_expect("R6 chain first", {8'h00, sbyte(0)});
    pop_expect("R6 chain second", {8'h00, sbyte(1)});
  endtask

  task automatic t_switch();
    clear_mon();
    push(mk(8'h01, 8'h00, 16'h0011));
    push(mk(8'h02, 8'h00, 16'h0022));
    wait_idle();
    check("R5 two low periods", run_n, 2);
    check("R5 gap at least one sclk", (gap_log[0] >= 2) ? 1 : 0, 1);
    check("R5 no direct swap", direct_chg, 0);
    check("R1 pattern 2 select", cs_log[8], 8'hFD);
    check("R3 low time second", run_log[1], 16);
    pop_expect("R6 switch first", {8'h00, sbyte(0)});
    pop_expect("R6 switch second", {8'h00, sbyte(1)});
  endtask

  task automatic t_attrs();
    clear_mon();
    push(mk(8'h01, 8'h01, 16'h0081));
    wait_idle();
    check("R3 divider 3 low time", run_log[0], 48);
    check("R3 divider 3 data", sent_bits(0, 8), 16'h0081);
    pop_expect("R6 slow frame", {8'h00, sbyte(0)});
    clear_mon();
    push(mk(8'h01, 8'h02, 16'hBEEF));
    wait_idle();
    check("R3 wide low time", run_log[0], 32);
    check("R3 wide bit count", bit_idx, 16);
    check("R2 wide data", sent_bits(0, 16), 16'hBEEF);
    pop_expect("R6 wide frame", {sbyte(0), sbyte(1)});
    clear_mon();
    push(mk(8'h01, 8'h09, 16'h0042));
    wait_idle();
    check("R3 out-of-range index uses set 0", run_log[0], 16);
    pop_expect("R6 fallback frame", {8'h00, sbyte(0)});
  endtask

  task automatic t_overrun();
    req_en = 1'b1; req_to_dma = 1'b1;
    clear_mon();
    for (int i = 0; i < 5; i++) push(mk(8'h01, 8'h00, 16'h0010 + 16'(i)));
    check("R9 queue full", tx_full, 1);
    check("R9 no dma request when full", dma_req, 0);
    check("R9 no irq request when full", irq_req, 0);
    push(mk(8'h01, 8'h00, 16'h0015));
    wait_idle();
    check("R7 transmission continued", bit_idx, 48);
    check("R7 overrun set", rx_overrun, 1);
    for (int k = 0; k < 4; k++) pop_expect("R7 kept oldest", {8'h00, sbyte(k)});
    @(negedge clk);
    check("R7 dropped extra", rx_empty, 1);
    check("R7 overrun sticky after reads", rx_overrun, 1);
  endtask

  task automatic t_clear();
    clear_mon();
    push(mk(8'h01, 8'h00, 16'h0077));
    push(mk(8'h01, 8'h00, 16'h0078));
    wait_idle();
    check("R8 data present before clear", rx_empty, 0);
    @(negedge clk); rx_clear = 1'b1;
    @(negedge clk); rx_clear = 1'b0;
    check("R8 emptied", rx_empty, 1);
    check("R8 overrun cleared", rx_overrun, 0);
    clear_mon();
    push(mk(8'h01, 8'h00, 16'h0079));
    wait_idle();
    pop_expect("R8 usable after clear", {8'h00, sbyte(0)});
  endtask

  initial begin
    rst_n = 1'b0; tx_wr_en = 1'b0; tx_wr_data = '0; rx_rd_en = 1'b0;
    rx_clear = 1'b0; req_en = 1'b0; req_to_dma = 1'b0;
    cfg_half_div = {4'd2, 4'd1, 4'd3, 4'd1};
    cfg_wide = 4'b0100;
    mon_clr = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1; mon_clr = 1'b0;
    repeat (4) @(posedge clk);
    t_reset();
    t_request();
    t_single();
    t_chain();
    t_switch();
    t_attrs();
    t_overrun();
    t_clear();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule